// File: doc/BRIEF.md
# Dual-Output Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents them to a processor as two request outputs: a normal request and a fast request. Each line passes through a synchronizer. Software decides, line by line, whether the line takes part at all (the enable bit) and which of the two outputs it drives (the route bit). Each output is simply the OR of the lines that are pending, enabled and routed to it. No priority is applied to the outputs themselves.

To shorten the interrupt handler, each output also has an encoded register. It holds the number of the winning pending line plus one, and zero means that nothing is pending. A separate error-class mask marks lines that always win the encoding over every ordinary line. Within either class, the lower line number wins.

All registers sit behind an APB slave with zero wait states. The slave is built as a three-state transfer machine:

- IDLE goes to SETUP when `psel` is high and `penable` is low.
- SETUP goes to ACCESS when `psel` and `penable` are both high, stays in SETUP while `penable` is still low, and returns to IDLE if `psel` drops.
- ACCESS goes to SETUP on a back-to-back transfer; otherwise it returns to IDLE.

A write takes effect on the clock edge that ends the access phase.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, the enable, route and error-class registers all read zero. Both outputs are low and both encoded registers read zero.
- R2: The raw status words return the synchronized state of the lines, whatever the enables say. Offset 0x18 holds lines 0–31 (bit n = line n) and offset 0x1C holds lines 32–63 (bit n = line 32+n).
- R3: The enable words sit at 0x00/0x04 and the route words at 0x08/0x0C; a route bit of 1 selects the fast output. The normal status words at 0x20/0x24 hold line AND enable AND NOT route. The fast status words at 0x28/0x2C hold line AND enable AND route. No line appears in both.
- R4: `nrm_irq_o` is the OR of the normal status bits and `fst_irq_o` is the OR of the fast status bits.
- R5: The encoded register at 0x30 (normal) or 0x34 (fast) returns, in bits 6:0, the lowest pending line number on that output plus one. It returns 0 when nothing is pending, so line 0 gives 1 and line 63 gives 64.
- R6: A pending line whose bit is set in the error-class mask (0x10 for lines 0–31, 0x14 for lines 32–63) wins the encoding over every ordinary line. Among error lines, the lowest number wins.
- R7: A change on a line reaches the status and the outputs two clock edges after it is applied, through a two-flop synchronizer.
- R8: Writes to the read-only offsets (0x18–0x34) change nothing. A read of an unmapped offset returns zero.
- R9: `pready` is always high, so every transfer completes with zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, held high |
| irq_src | input | 64 | Level-sensitive interrupt request lines |
| nrm_irq_o | output | 1 | Normal interrupt request |
| fst_irq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 lines, 32-bit register words and two synchronizer stages. With these values, the upper register halves are exercised, and so is the largest encoded value, 64, which fills the 7-bit field. With two synchronizer stages, the bench can confirm that a line change is invisible after one edge and visible after the second. The same configuration lets an error-class line in the upper half beat ordinary lines in the lower half on the same output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS
    } apb_state_e;

    // register bank index taken from paddr[7:3]; paddr[2] picks the half
    localparam logic [4:0] BANK_ENABLE = 5'd0;
    localparam logic [4:0] BANK_ROUTE  = 5'd1;
    localparam logic [4:0] BANK_ERRCLS = 5'd2;
    localparam logic [4:0] BANK_RAW    = 5'd3;
    localparam logic [4:0] BANK_NRM    = 5'd4;
    localparam logic [4:0] BANK_FST    = 5'd5;
    localparam logic [4:0] BANK_CODE   = 5'd6;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else begin
                    if (s == 0) chain[s] <= d_in;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N      = 64,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      err_mask,
    output logic [CODE_W-1:0] code
);
    logic [N-1:0]      err_pend;
    logic [CODE_W-1:0] ord_code;
    logic [CODE_W-1:0] err_code;

    assign err_pend = pend & err_mask;

    // scan from the top so the lowest set index is written last
    always_comb begin
        ord_code = '0;
        err_code = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (pend[i])     ord_code = CODE_W'(i + 1);
            if (err_pend[i]) err_code = CODE_W'(i + 1);
        end
    end

    assign code = (|err_pend) ? err_code : ord_code;
endmodule

// File: rtl/irqc_apb_regs.sv
module irqc_apb_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int REG_W   = 32,
    parameter int CODE_W  = 7
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [7:0]         paddr,
    input  logic [REG_W-1:0]   pwdata,
    output logic [REG_W-1:0]   prdata,
    output logic               pready,
    input  logic [NUM_SRC-1:0] raw_st,
    input  logic [NUM_SRC-1:0] nrm_st,
    input  logic [NUM_SRC-1:0] fst_st,
    input  logic [CODE_W-1:0]  nrm_code,
    input  logic [CODE_W-1:0]  fst_code,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] route_q,
    output logic [NUM_SRC-1:0] err_q
);
    localparam int HALF = NUM_SRC / 2;

    apb_state_e state, state_nxt;
    logic       wr_en;
    logic       rd_en;
    logic [4:0] bank;
    logic       hi;

    assign bank = paddr[7:3];
    assign hi   = paddr[2];

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state <= ST_IDLE;
        else          state <= state_nxt;
    end

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE:   state_nxt = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  begin
                if (!psel)        state_nxt = ST_IDLE;
                else if (penable) state_nxt = ST_ACCESS;
                else              state_nxt = ST_SETUP;
            end
            ST_ACCESS: state_nxt = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    assign wr_en = (state == ST_SETUP) && psel && penable && pwrite;
    assign rd_en = psel && penable && !pwrite;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            en_q    <= '0;
            route_q <= '0;
            err_q   <= '0;
        end else if (wr_en) begin
            case (bank)
                BANK_ENABLE: if (hi) en_q[NUM_SRC-1:HALF]    <= pwdata[HALF-1:0];
                             else    en_q[HALF-1:0]          <= pwdata[HALF-1:0];
                BANK_ROUTE:  if (hi) route_q[NUM_SRC-1:HALF] <= pwdata[HALF-1:0];
                             else    route_q[HALF-1:0]       <= pwdata[HALF-1:0];
                BANK_ERRCLS: if (hi) err_q[NUM_SRC-1:HALF]   <= pwdata[HALF-1:0];
                             else    err_q[HALF-1:0]         <= pwdata[HALF-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        pready = 1'b1;
        if (rd_en) begin
            case (bank)
                BANK_ENABLE: prdata = REG_W'(hi ? en_q[NUM_SRC-1:HALF]    : en_q[HALF-1:0]);
                BANK_ROUTE:  prdata = REG_W'(hi ? route_q[NUM_SRC-1:HALF] : route_q[HALF-1:0]);
                BANK_ERRCLS: prdata = REG_W'(hi ? err_q[NUM_SRC-1:HALF]   : err_q[HALF-1:0]);
                BANK_RAW:    prdata = REG_W'(hi ? raw_st[NUM_SRC-1:HALF]  : raw_st[HALF-1:0]);
                BANK_NRM:    prdata = REG_W'(hi ? nrm_st[NUM_SRC-1:HALF]  : nrm_st[HALF-1:0]);
                BANK_FST:    prdata = REG_W'(hi ? fst_st[NUM_SRC-1:HALF]  : fst_st[HALF-1:0]);
                BANK_CODE:   prdata = REG_W'(hi ? fst_code : nrm_code);
                default:     prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
    parameter int NUM_SRC     = 64,
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [7:0]         paddr,
    input  logic [REG_W-1:0]   pwdata,
    output logic [REG_W-1:0]   prdata,
    output logic               pready,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               nrm_irq_o,
    output logic               fst_irq_o
);
    localparam int CODE_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] route_q;
    logic [NUM_SRC-1:0] err_q;
    logic [NUM_SRC-1:0] nrm_st;
    logic [NUM_SRC-1:0] fst_st;
    logic [CODE_W-1:0]  nrm_code;
    logic [CODE_W-1:0]  fst_code;

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d_in  (irq_src),
        .q_out (sync_q)
    );

    assign nrm_st = sync_q & en_q & ~route_q;
    assign fst_st = sync_q & en_q &  route_q;

    irqc_prio_enc #(.N(NUM_SRC), .CODE_W(CODE_W)) u_enc_nrm (
        .pend     (nrm_st),
        .err_mask (err_q),
        .code     (nrm_code)
    );

    irqc_prio_enc #(.N(NUM_SRC), .CODE_W(CODE_W)) u_enc_fst (
        .pend     (fst_st),
        .err_mask (err_q),
        .code     (fst_code)
    );

    irqc_apb_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .CODE_W(CODE_W)) u_regs (
        .pclk     (pclk),
        .presetn  (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pready   (pready),
        .raw_st   (sync_q),
        .nrm_st   (nrm_st),
        .fst_st   (fst_st),
        .nrm_code (nrm_code),
        .fst_code (fst_code),
        .en_q     (en_q),
        .route_q  (route_q),
        .err_q    (err_q)
    );

    assign nrm_irq_o = |nrm_st;
    assign fst_irq_o = |fst_st;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC = 64,
    parameter int CODE_W  = 7
) (
    input logic               pclk,
    input logic               presetn,
    input logic               pready,
    input logic [NUM_SRC-1:0] irq_src,
    input logic [NUM_SRC-1:0] sync_q,
    input logic [NUM_SRC-1:0] nrm_st,
    input logic [NUM_SRC-1:0] fst_st,
    input logic [NUM_SRC-1:0] err_q,
    input logic [CODE_W-1:0]  nrm_code,
    input logic [CODE_W-1:0]  fst_code,
    input logic               nrm_irq_o,
    input logic               fst_irq_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [1:0]       since_rst;
    logic [IDX_W-1:0] nrm_idx;
    logic [IDX_W-1:0] fst_idx;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)             since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign nrm_idx = IDX_W'(nrm_code - 1'b1);
    assign fst_idx = IDX_W'(fst_code - 1'b1);

    AST_PREADY_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
        pready);                                                     // R9
    AST_SYNC_DELAY: assert property (@(posedge pclk) disable iff (!presetn)
        (since_rst >= 2'd2) |-> (sync_q == $past(irq_src, 2)));      // R7
    AST_ROUTE_EXCL: assert property (@(posedge pclk) disable iff (!presetn)
        ((nrm_st & fst_st) == '0));                                  // R3
    AST_NRM_OUT_CODE: assert property (@(posedge pclk) disable iff (!presetn)
        (nrm_irq_o == (nrm_code != '0)));                            // R4
    AST_FST_OUT_CODE: assert property (@(posedge pclk) disable iff (!presetn)
        (fst_irq_o == (fst_code != '0)));                            // R4
    AST_CODE_RANGE: assert property (@(posedge pclk) disable iff (!presetn)
        (nrm_code <= CODE_W'(NUM_SRC)) && (fst_code <= CODE_W'(NUM_SRC))); // R5
    AST_NRM_ERR_WIN: assert property (@(posedge pclk) disable iff (!presetn)
        ((nrm_st & err_q) != '0) |-> err_q[nrm_idx]);                // R6
    AST_FST_ERR_WIN: assert property (@(posedge pclk) disable iff (!presetn)
        ((fst_st & err_q) != '0) |-> err_q[fst_idx]);                // R6
endmodule

bind dual_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_chk (
    .pclk      (pclk),
    .presetn   (presetn),
    .pready    (pready),
    .irq_src   (irq_src),
    .sync_q    (sync_q),
    .nrm_st    (nrm_st),
    .fst_st    (fst_st),
    .err_q     (err_q),
    .nrm_code  (nrm_code),
    .fst_code  (fst_code),
    .nrm_irq_o (nrm_irq_o),
    .fst_irq_o (fst_irq_o)
);

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
    localparam int CLK_P = 10;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [63:0] irq_src = '0;
    logic        nrm_irq_o, fst_irq_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // bench-side copy of the programmed control state
    logic [63:0] m_en = '0, m_route = '0, m_err = '0;

    always #(CLK_P/2) pclk = ~pclk;

    dual_irq_ctrl i_dual_irq_ctrl (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .irq_src(irq_src), .nrm_irq_o(nrm_irq_o),
        .fst_irq_o(fst_irq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] model_code(input logic [63:0] p, input logic [63:0] e);
        for (int i = 0; i < 64; i++) if (p[i] && e[i]) return 7'(i + 1);
        for (int i = 0; i < 64; i++) if (p[i]) return 7'(i + 1);
        return 7'd0;
    endfunction

    // monitor: compares each completed read against the scoreboard head
    always @(negedge pclk) begin
        if (psel && penable && !pwrite) begin
            chk("R9 pready", {63'd0, pready}, 64'd1);
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 64'd1, 64'd0);
            end else begin
                chk(tag_q.pop_front(), {32'd0, prdata}, {32'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge pclk); #1; penable = 1;
        @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge pclk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge pclk); #1; penable = 1;
        @(posedge pclk); #1; psel = 0; penable = 0;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(posedge pclk); #1; irq_src = v;
        repeat (2) @(posedge pclk);
        #1;
    endtask

    task automatic prog(input logic [63:0] en, input logic [63:0] rt, input logic [63:0] er);
        apb_write(8'h00, en[31:0]);  apb_write(8'h04, en[63:32]);
        apb_write(8'h08, rt[31:0]);  apb_write(8'h0C, rt[63:32]);
        apb_write(8'h10, er[31:0]);  apb_write(8'h14, er[63:32]);
        m_en = en; m_route = rt; m_err = er;
    endtask

    task automatic check_all(input string tag);
        logic [63:0] n = irq_src & m_en & ~m_route;
        logic [63:0] f = irq_src & m_en &  m_route;
        expect_read(8'h18, irq_src[31:0],  {"R2 raw lo ", tag});
        expect_read(8'h1C, irq_src[63:32], {"R2 raw hi ", tag});
        expect_read(8'h20, n[31:0],  {"R3 nrm lo ", tag});
        expect_read(8'h24, n[63:32], {"R3 nrm hi ", tag});
        expect_read(8'h28, f[31:0],  {"R3 fst lo ", tag});
        expect_read(8'h2C, f[63:32], {"R3 fst hi ", tag});
        expect_read(8'h30, {25'd0, model_code(n, m_err)}, {"R5 R6 nrm code ", tag});
        expect_read(8'h34, {25'd0, model_code(f, m_err)}, {"R5 R6 fst code ", tag});
        @(negedge pclk);
        chk({"R4 nrm out ", tag}, {63'd0, nrm_irq_o}, {63'd0, |n});
        chk({"R4 fst out ", tag}, {63'd0, fst_irq_o}, {63'd0, |f});
    endtask

    initial begin
        #(CLK_P * 150000);
        chk("watchdog", 64'd1, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge pclk);
        #1 presetn = 1;

        // R1: reset state
        @(negedge pclk);
        chk("R1 nrm out", {63'd0, nrm_irq_o}, 64'd0);
        chk("R1 fst out", {63'd0, fst_irq_o}, 64'd0);
        for (int a = 0; a < 6; a++) expect_read(8'(a * 4), 32'd0, "R1 ctrl reg");
        expect_read(8'h30, 32'd0, "R1 nrm code");
        expect_read(8'h34, 32'd0, "R1 fst code");

        // R2: raw status visible with everything disabled
        set_src(64'hA5A5_0001_8000_0300);
        check_all("disabled");

        // R3 R4 R5: mixed routing across both halves
        prog(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_F0F0_F0F0, 64'd0);
        check_all("mixed");
        set_src(64'h0000_0000_0000_0001);
        check_all("line0");
        set_src(64'h8000_0000_0000_0000);
        check_all("line63");
        set_src(64'd0);
        check_all("none");

        // R6: error line 52 beats ordinary lines on the normal output
        prog(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_F0F0_F0F0, 64'h0010_0000_0000_0000);
        set_src(64'h0010_0000_0000_0006);
        check_all("err wins");
        // two error lines on the fast output: lower index wins
        prog(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0000_0000_0010);
        set_src(64'h0001_0000_0000_0013);
        check_all("two err");

        // enable cleared for a pending line removes it
        prog(64'hFFFF_FFFF_FFFF_FFEF, 64'd0, 64'd0);
        check_all("masked");

        // R8: writes to read-only offsets are ignored, unmapped reads zero
        apb_write(8'h18, 32'hDEAD_BEEF);
        apb_write(8'h30, 32'h0000_007F);
        apb_write(8'h20, 32'hFFFF_FFFF);
        check_all("R8 ro write");
        expect_read(8'h3C, 32'd0, "R8 unmapped");
        expect_read(8'h80, 32'd0, "R8 unmapped high");

        // R7: two-edge synchronizer latency
        prog(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0);
        set_src(64'd0);
        @(posedge pclk); #1 irq_src = 64'h0000_0000_0000_0100;
        @(posedge pclk); @(negedge pclk);
        chk("R7 after one edge", {63'd0, nrm_irq_o}, 64'd0);
        @(posedge pclk); @(negedge pclk);
        chk("R7 after two edges", {63'd0, nrm_irq_o}, 64'd1);
        expect_read(8'h30, 32'd9, "R7 code line8");

        repeat (3) @(posedge pclk);
        chk("R9 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule